// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Wakeup Bit

This block sends one byte at a time as an asynchronous serial frame on a single line. A byte comes in over a valid/ready handshake. The frame is then shifted out one bit at a time. Bit timing comes from an external baud tick, and each bit lasts a fixed number of ticks. The baud-rate divider sits outside the block, and it must produce ticks fast enough for line rates up to 500 kbit/s.

Frame layout, in the order the bits leave the line:

- a low start bit;
- eight data bits, least-significant bit first;
- an optional wakeup bit with a configured value;
- an optional parity bit, even or odd;
- one or two high stop bits.

A slot that is disabled is removed from the frame, so the frame shrinks by that bit. The configuration is taken at the same edge as the byte. A frame in flight therefore keeps its own format, even if the configuration inputs change mid-frame.

An active-low clear-to-send input holds back the start of a new frame. It never cuts a frame that has already begun.

Top module: `wk_async_tx`

## Requirements
- R1: After reset the line is high. While idle, `in_ready` equals the inverse of `cts_n`.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. The line goes low for the start bit from the next cycle. Every bit of the frame lasts exactly 16 baud ticks, counting only cycles with `baud_tick` high.
- R3: After the start bit, the eight data bits follow least-significant bit first.
- R4: When `cfg_wake_en` is 1, one bit of value `cfg_wake_val` follows the data. When it is 0, no such bit is sent.
- R5: When `cfg_par_en` is 1, a parity bit follows the wakeup slot. The parity bit is the XOR of the data bits, inverted when `cfg_par_odd` is 1, so that the data plus parity hold an even number of ones (even mode) or an odd number (odd mode). When `cfg_par_en` is 0, no parity bit is sent.
- R6: The frame ends with high stop bits: one when `cfg_two_stop` is 0, two when it is 1. Right after the last stop bit the block is idle again, with the line high.
- R7: While `cts_n` is high, no frame starts and `in_ready` stays low. A frame already started runs to its end whatever `cts_n` does.
- R8: `in_ready` is low for the whole frame. Changes on `in_data` and `in_valid` during a frame have no effect on the bits sent.
- R9: The configuration inputs are sampled at acceptance. Changing them during a frame does not alter that frame's layout or bit values.
- R10: The line changes only on a cycle that follows an accepting edge or a cycle with `baud_tick` high. Gaps between ticks stretch the bits in proportion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_wake_en | input | 1 | Include the wakeup bit |
| cfg_wake_val | input | 1 | Value of the wakeup bit |
| cfg_par_en | input | 1 | Include the parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| cts_n | input | 1 | Clear-to-send, active low, gates frame start |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can accept a byte this cycle |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The assertions assume that the inputs change only between clock edges and that `baud_tick` is a plain level sampled at each edge. They make no assumption about the spacing between ticks. Under that assumption they check four things:

- the line is high whenever the block is ready;
- ready never appears while clear-to-send is high;
- an accepted byte is followed by a low line;
- the line holds still between ticks.

The stimulus drives every input on the falling clock edge. It sweeps all 32 settings of the five configuration inputs, using several bytes for each setting. It alternates between three tick patterns: ticks on every cycle, ticks every third cycle, and ticks with irregular spacing. Within a frame, it flips the configuration and the byte after each acceptance, and it also raises clear-to-send mid-frame.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } wk_state_e;

    typedef struct packed {
        logic wake_en;
        logic wake_val;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } wk_cfg_t;
endpackage

// File: rtl/wk_frame_pack.sv
module wk_frame_pack
    import wk_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int FRAME_MAX = DATA_W + 5,
    localparam int LEN_W = $clog2(FRAME_MAX + 1)
) (
    input  logic [DATA_W-1:0]    data,
    input  wk_cfg_t              cfg,
    output logic [FRAME_MAX-1:0] frame,
    output logic [LEN_W-1:0]     frame_len
);
    logic par_bit;
    int   pos;

    assign par_bit = (^data) ^ cfg.par_odd;

    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            frame[i+1] = data[i];
        end
        pos = DATA_W + 1;
        if (cfg.wake_en) begin
            frame[pos] = cfg.wake_val;
            pos = pos + 1;
        end
        if (cfg.par_en) begin
            frame[pos] = par_bit;
        end
        frame_len = LEN_W'(DATA_W + 2) + LEN_W'(cfg.wake_en) + LEN_W'(cfg.par_en)
                  + LEN_W'(cfg.two_stop);
    end
endmodule

// File: rtl/wk_bit_timer.sv
module wk_bit_timer #(
    parameter int TICKS_PER_BIT = 16,
    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign bit_end = run && tick && (cnt_q == CNT_W'(TICKS_PER_BIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = bit_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/wk_async_tx.sv
module wk_async_tx
    import wk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              cfg_wake_en,
    input  logic              cfg_wake_val,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cts_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx_line
);
    localparam int FRAME_MAX = DATA_W + 5;
    localparam int LEN_W = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        wk_state_e            state;
        logic [FRAME_MAX-1:0] shift;
        logic [LEN_W-1:0]     left;
    } tx_regs_t;

    tx_regs_t             r_d, r_q;
    wk_cfg_t              cfg_in;
    logic [FRAME_MAX-1:0] frame_vec;
    logic [LEN_W-1:0]     frame_len;
    logic                 bit_end;
    logic                 accept;

    assign cfg_in = '{wake_en: cfg_wake_en, wake_val: cfg_wake_val, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    wk_frame_pack #(.DATA_W(DATA_W)) i_pack (
        .data      (in_data),
        .cfg       (cfg_in),
        .frame     (frame_vec),
        .frame_len (frame_len)
    );

    wk_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.state == ST_SEND),
        .tick    (baud_tick),
        .bit_end (bit_end)
    );

    assign in_ready = (r_q.state == ST_IDLE) && !cts_n;
    assign accept   = in_valid && in_ready;
    assign tx_line  = (r_q.state == ST_SEND) ? r_q.shift[0] : 1'b1;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    r_d.state = ST_SEND;
                    r_d.shift = frame_vec;
                    r_d.left  = frame_len;
                end
            end
            ST_SEND: begin
                if (bit_end) begin
                    r_d.shift = {1'b1, r_q.shift[FRAME_MAX-1:1]};
                    r_d.left  = r_q.left - 1'b1;
                    if (r_q.left == LEN_W'(1)) begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.shift <= '1;
            r_q.left  <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/wk_async_tx_chk.sv
module wk_async_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic cts_n,
    input logic in_valid,
    input logic in_ready,
    input logic tx_line
);
    // R1: a ready block is idle, so its line is high
    a_r1_ready_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_line);

    // R7: no ready while clear-to-send is withheld
    a_r7_cts_gates_ready: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !cts_n);

    // R2: acceptance is followed by the start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !tx_line);

    // R10: line only moves after a tick or an acceptance
    a_r10_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(baud_tick) && !$past(in_valid && in_ready)) |-> $stable(tx_line));
endmodule

bind wk_async_tx wk_async_tx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .cts_n     (cts_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_line   (tx_line)
);

// File: tb/test_wk_async_tx.sv
module test_wk_async_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       cfg_wake_en = 1'b0, cfg_wake_val = 1'b0, cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       cts_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, tx_line;

    int errors = 0;
    int checks = 0;
    int tick_mode = 0;
    int cyc = 0;
    logic [7:0] lfsr = 8'h5B;

    always #2.5 clk = ~clk;

    wk_async_tx i_wk_async_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .cfg_wake_en(cfg_wake_en), .cfg_wake_val(cfg_wake_val), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .cts_n(cts_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .tx_line(tx_line)
    );

    // tick pattern driven at falling edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (tick_mode)
            0: baud_tick <= 1'b1;
            1: baud_tick <= (cyc % 3 == 0);
            default: baud_tick <= lfsr[0] | lfsr[3];
        endcase
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic count_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (baud_tick) k++;
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [4:0] c, input bit drop_cts);
        logic exp_bits [0:15];
        int   n;
        int   wait_c;
        logic par;
        // expected frame built from the requirements
        n = 0;
        exp_bits[n] = 1'b0; n++;                                   // R2 start
        for (int i = 0; i < 8; i++) begin exp_bits[n] = d[i]; n++; end  // R3
        if (c[4]) begin exp_bits[n] = c[3]; n++; end               // R4
        par = (^d) ^ c[1];
        if (c[2]) begin exp_bits[n] = par; n++; end                // R5
        exp_bits[n] = 1'b1; n++;                                   // R6
        if (c[0]) begin exp_bits[n] = 1'b1; n++; end

        @(negedge clk);
        {cfg_wake_en, cfg_wake_val, cfg_par_en, cfg_par_odd, cfg_two_stop} = c;
        in_data  = d;
        in_valid = 1'b1;
        wait_c = 0;
        while (!in_ready && wait_c < 100) begin @(negedge clk); wait_c++; end
        chk(in_ready == 1'b1, "R1 ready when idle", int'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        // disturb inputs after acceptance (R8, R9)
        in_data = ~d;
        {cfg_wake_en, cfg_wake_val, cfg_par_en, cfg_par_odd, cfg_two_stop} = ~c;
        in_valid = (d[0] == 1'b1);
        for (int b = 0; b < n; b++) begin
            count_ticks(8);
            @(negedge clk);
            if (b == 0)
                chk(tx_line == exp_bits[b], "R2 start bit", int'(tx_line), int'(exp_bits[b]));
            else if (b < 9)
                chk(tx_line == exp_bits[b], "R3 data bit", int'(tx_line), int'(exp_bits[b]));
            else if (b < n - 1 - int'(c[0]))
                chk(tx_line == exp_bits[b], "R4/R5 wake or parity bit", int'(tx_line), int'(exp_bits[b]));
            else
                chk(tx_line == exp_bits[b], "R6 stop bit", int'(tx_line), int'(exp_bits[b]));
            chk(in_ready == 1'b0, "R8 ready low in frame", int'(in_ready), 0);
            if (drop_cts && b == 3) cts_n = 1'b1;
            count_ticks(8);
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk(tx_line == 1'b1, "R6 idle after stop", int'(tx_line), 1);
        chk(in_ready == !cts_n, "R9 frame length matches sampled config", int'(in_ready), int'(!cts_n));
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] pats [0:5];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
        pats[3] = 8'h5A; pats[4] = 8'h01; pats[5] = 8'h80;
        repeat (3) @(negedge clk);
        chk(tx_line == 1'b1, "R1 line high in reset", int'(tx_line), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line == 1'b1, "R1 line high after reset", int'(tx_line), 1);
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

        // R7: no start while clear-to-send is high
        cts_n = 1'b1;
        in_valid = 1'b1;
        in_data = 8'h3C;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i % 10 == 0) begin
                chk(in_ready == 1'b0, "R7 ready held by cts", int'(in_ready), 0);
                chk(tx_line == 1'b1, "R7 line idle while cts high", int'(tx_line), 1);
            end
        end
        in_valid = 1'b0;
        cts_n = 1'b0;

        // sweep of all configurations
        for (int c = 0; c < 32; c++) begin
            tick_mode = c % 3;
            for (int p = 0; p < 6; p++) begin
                send_frame(pats[p] ^ 8'(c * 7), 5'(c), 1'b0);
            end
        end

        // R7: frame completes after cts rises mid-frame
        tick_mode = 0;
        send_frame(8'h96, 5'b10110, 1'b1);
        repeat (20) @(negedge clk);
        chk(in_ready == 1'b0, "R7 no ready after cts rose", int'(in_ready), 0);
        chk(tx_line == 1'b1, "R7 line idle after completed frame", int'(tx_line), 1);
        cts_n = 1'b0;
        send_frame(8'h3C, 5'b11101, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule